// File: doc/BRIEF.md
# Rotated Framebuffer Parameter Calculator

This block turns a description of a framebuffer into the numbers a two-level (element/frame) indexed DMA needs to read the picture in a rotated and optionally mirrored order. The inputs are a base byte address, an element size code, the visible width and height in pixels, the virtual line width, horizontal and vertical scale factors, a quarter-turn rotation code, a mirror flag and a legacy flag. The outputs are the first and last byte addresses of the scan, the number of elements per frame, the number of frames, and two signed byte steps. One step is applied between elements and the other between frames.

Every corner address and step comes from one pixel offset expression: `((y * vwidth * yscale) + (x * xscale)) * esize`. Each of the eight scan orders only chooses which coordinates feed that expression. A single multiplier is shared over three cycles to form the row pitch, the horizontal span and the vertical span. A final state assembles the results.

The control is a small state machine:
- ST_IDLE waits for `start` and latches the operands.
- ST_CHECK validates them. On an error it returns to ST_IDLE, otherwise it moves on to ST_PITCH.
- ST_PITCH, ST_XSPAN and ST_YSPAN each perform one multiplication, in that order.
- ST_FINAL writes the results, pulses `done` and returns to ST_IDLE.

Top module: `rfb_param_calc`

## Requirements
- R1: A `virt_width` of 0 is replaced by `width`. A `x_scale` or `y_scale` of 0 is replaced by 1.
- R2: The byte address of pixel (x,y) is `base_addr + (y*vw*ys + x*xs)*es`, taken modulo 2^ADDR_W. Here `elem_code` 0/1/2 gives es = 1/2/4 bytes. `rot_code` 0/1/2/3 selects 0/90/180/270 degrees.
  - Unmirrored corners (top, bottom), with W = width-1 and H = height-1:
    - 0 degrees: (0,0), (W,H)
    - 90 degrees: (0,H), (W,0)
    - 180 degrees: (W,H), (0,0)
    - 270 degrees: (W,0), (0,H)
  - Mirrored corners (top, bottom):
    - 0 degrees: (W,0), (0,H)
    - 90 degrees: (W,H), (0,0)
    - 180 degrees: (0,H), (W,0)
    - 270 degrees: (0,0), (W,H)
- R3: A step from pixel S to pixel D is `addr(D) - addr(S) - es + 1`. It is reported as a two's-complement value of STEP_W bits. The element step and frame step, each written as S->D, are:
  - Unmirrored:
    - 0 degrees: element (0,0)->(1,0), frame (W,0)->(0,1)
    - 90 degrees: element (0,1)->(0,0), frame (0,0)->(1,H)
    - 180 degrees: element (1,0)->(0,0), frame (0,1)->(W,0)
    - 270 degrees: element (0,0)->(0,1), frame (1,H)->(0,0)
  - Mirrored:
    - 0 degrees: element (1,0)->(0,0), frame (0,0)->(W,1)
    - 90 degrees: element (0,1)->(0,0), frame (1,0)->(0,H)
    - 180 degrees: element (0,0)->(1,0), frame (W,1)->(0,0)
    - 270 degrees: element (0,0)->(0,1), frame (0,H)->(1,0)
- R4: At 0 and 180 degrees, `elem_count` = width and `frame_count` = height. At 90 and 270 degrees the two are swapped.
- R5: A geometry error is an effective virtual width below `width`, or a `width` of 0, or a `height` of 0. It sets `err_geom`, pulses `done` and leaves all results unchanged.
- R6: A `rot_code` of 4 to 7 or an `elem_code` of 3 sets `err_mode`, pulses `done` and leaves all results unchanged.
- R7: When `legacy_mode` is set, es is 4, rotation is 0 and mirror is clear, the bottom address is increased by 2. In every other case no adjustment is made.
- R8: After reset, `busy`, `done`, both error flags and all results are 0.
  - `start` is accepted only while idle. `busy` is high from the cycle after acceptance until completion.
  - `done` is a one-cycle pulse, 5 cycles after the accepting edge on success and 1 cycle after it on error.
  - A `start` raised while busy is ignored.
- R9: Results and error flags hold their values from `done` until the next accepted `start`, whatever the other inputs do. Both error flags clear on acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calculation (accepted when idle) |
| base_addr | input | ADDR_W | Byte address of pixel (0,0) |
| elem_code | input | 2 | Element size code: 0=1, 1=2, 2=4 bytes |
| width | input | DIM_W | Visible width in pixels |
| height | input | DIM_W | Visible height in pixels |
| virt_width | input | DIM_W | Line pitch in pixels, 0 = width |
| x_scale | input | SCALE_W | Horizontal pixel stride, 0 = 1 |
| y_scale | input | SCALE_W | Vertical line stride, 0 = 1 |
| rot_code | input | 3 | 0/1/2/3 = 0/90/180/270 degrees |
| mirror | input | 1 | Mirror the rows |
| legacy_mode | input | 1 | Enable the bottom address adjustment for 4-byte elements |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_geom | output | 1 | Geometry error of last request |
| err_mode | output | 1 | Illegal rotation or size code in last request |
| top_addr | output | ADDR_W | First byte address of the scan |
| bottom_addr | output | ADDR_W | Last byte address of the scan |
| elem_count | output | DIM_W | Elements per frame |
| frame_count | output | DIM_W | Frames |
| elem_step | output | STEP_W | Signed step between elements |
| frame_step | output | STEP_W | Signed step between frames |

## Verification
The bench builds the block with ADDR_W = 32, DIM_W = 10 and SCALE_W = 3. These narrow dimensions let a 1023 x 1023 picture with scale 7 and 4-byte elements exercise the widest vertical span product and the largest negative steps at their full widths. A base address close to the top of the 32-bit space exercises the modulo wrap of the corner addresses. The vector table visits all eight rotation and mirror orders across the three element sizes and the 1 x 1 minimum. The directed tests cover each error path, a start while busy and a hold interval with changing inputs.

// File: rtl/rfb_pkg.sv
package rfb_pkg;

    // coordinate selector for one axis of a corner point
    typedef enum logic [1:0] {
        CO_ZERO = 2'd0,
        CO_ONE  = 2'd1,
        CO_MAX  = 2'd2
    } coord_e;

    typedef struct packed {
        coord_e x;
        coord_e y;
    } pt_t;

    // points that define one scan order
    typedef struct packed {
        pt_t top;
        pt_t bot;
        pt_t e_src;
        pt_t e_dst;
        pt_t f_src;
        pt_t f_dst;
    } scan_plan_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CHECK = 3'd1,
        ST_PITCH = 3'd2,
        ST_XSPAN = 3'd3,
        ST_YSPAN = 3'd4,
        ST_FINAL = 3'd5
    } state_e;

endpackage

// File: rtl/rfb_mul.sv
module rfb_mul #(
    parameter int A_W = 12,
    parameter int B_W = 16,
    localparam int P_W = A_W + B_W
) (
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic [P_W-1:0] p
);
    logic [P_W-1:0] a_x;
    logic [P_W-1:0] b_x;

    assign a_x = P_W'(a);
    assign b_x = P_W'(b);
    assign p   = a_x * b_x;
endmodule

// File: rtl/rfb_scan_order.sv
module rfb_scan_order
    import rfb_pkg::*;
(
    input  logic [1:0] quad,
    input  logic       mirror,
    output scan_plan_t plan,
    output logic       swap_dims
);
    function automatic pt_t pt(input coord_e x, input coord_e y);
        pt_t r;
        r.x = x;
        r.y = y;
        return r;
    endfunction

    function automatic scan_plan_t mk(input pt_t t, input pt_t b,
                                      input pt_t es, input pt_t ed,
                                      input pt_t fs, input pt_t fd);
        scan_plan_t r;
        r.top   = t;
        r.bot   = b;
        r.e_src = es;
        r.e_dst = ed;
        r.f_src = fs;
        r.f_dst = fd;
        return r;
    endfunction

    assign swap_dims = quad[0];

    always_comb begin
        unique case ({quad, mirror})
            3'b00_0: plan = mk(pt(CO_ZERO, CO_ZERO), pt(CO_MAX,  CO_MAX),
                               pt(CO_ZERO, CO_ZERO), pt(CO_ONE,  CO_ZERO),
                               pt(CO_MAX,  CO_ZERO), pt(CO_ZERO, CO_ONE));
            3'b00_1: plan = mk(pt(CO_MAX,  CO_ZERO), pt(CO_ZERO, CO_MAX),
                               pt(CO_ONE,  CO_ZERO), pt(CO_ZERO, CO_ZERO),
                               pt(CO_ZERO, CO_ZERO), pt(CO_MAX,  CO_ONE));
            3'b01_0: plan = mk(pt(CO_ZERO, CO_MAX),  pt(CO_MAX,  CO_ZERO),
                               pt(CO_ZERO, CO_ONE),  pt(CO_ZERO, CO_ZERO),
                               pt(CO_ZERO, CO_ZERO), pt(CO_ONE,  CO_MAX));
            3'b01_1: plan = mk(pt(CO_MAX,  CO_MAX),  pt(CO_ZERO, CO_ZERO),
                               pt(CO_ZERO, CO_ONE),  pt(CO_ZERO, CO_ZERO),
                               pt(CO_ONE,  CO_ZERO), pt(CO_ZERO, CO_MAX));
            3'b10_0: plan = mk(pt(CO_MAX,  CO_MAX),  pt(CO_ZERO, CO_ZERO),
                               pt(CO_ONE,  CO_ZERO), pt(CO_ZERO, CO_ZERO),
                               pt(CO_ZERO, CO_ONE),  pt(CO_MAX,  CO_ZERO));
            3'b10_1: plan = mk(pt(CO_ZERO, CO_MAX),  pt(CO_MAX,  CO_ZERO),
                               pt(CO_ZERO, CO_ZERO), pt(CO_ONE,  CO_ZERO),
                               pt(CO_MAX,  CO_ONE),  pt(CO_ZERO, CO_ZERO));
            3'b11_0: plan = mk(pt(CO_MAX,  CO_ZERO), pt(CO_ZERO, CO_MAX),
                               pt(CO_ZERO, CO_ZERO), pt(CO_ZERO, CO_ONE),
                               pt(CO_ONE,  CO_MAX),  pt(CO_ZERO, CO_ZERO));
            default: plan = mk(pt(CO_ZERO, CO_ZERO), pt(CO_MAX,  CO_MAX),
                               pt(CO_ZERO, CO_ZERO), pt(CO_ZERO, CO_ONE),
                               pt(CO_ZERO, CO_MAX),  pt(CO_ONE,  CO_ZERO));
        endcase
    end
endmodule

// File: rtl/rfb_corner_math.sv
module rfb_corner_math
    import rfb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int PITCH_W = 16,
    parameter int OFF_W   = 28,
    parameter int STEP_W  = 32
) (
    input  logic [ADDR_W-1:0]        base,
    input  logic [PITCH_W-1:0]       xs,
    input  logic [PITCH_W-1:0]       xw,
    input  logic [PITCH_W-1:0]       rp,
    input  logic [OFF_W-1:0]         yh,
    input  logic [1:0]               esh,
    input  logic                     bump,
    input  scan_plan_t               plan,
    output logic [ADDR_W-1:0]        top,
    output logic [ADDR_W-1:0]        bot,
    output logic signed [STEP_W-1:0] estep,
    output logic signed [STEP_W-1:0] fstep
);
    localparam int BYTE_W = OFF_W + 2;

    // element offset of one corner: x part plus y part
    function automatic logic [OFF_W-1:0] offset_of(
        input pt_t p, input logic [PITCH_W-1:0] x1, input logic [PITCH_W-1:0] xm,
        input logic [PITCH_W-1:0] y1, input logic [OFF_W-1:0] ym);
        logic [OFF_W-1:0] xo;
        logic [OFF_W-1:0] yo;
        case (p.x)
            CO_ONE:  xo = OFF_W'(x1);
            CO_MAX:  xo = OFF_W'(xm);
            default: xo = '0;
        endcase
        case (p.y)
            CO_ONE:  yo = OFF_W'(y1);
            CO_MAX:  yo = ym;
            default: yo = '0;
        endcase
        return xo + yo;
    endfunction

    function automatic logic signed [STEP_W-1:0] step_of(
        input logic [OFF_W-1:0] s, input logic [OFF_W-1:0] d, input logic [1:0] sh);
        logic signed [STEP_W-1:0] ds;
        logic signed [STEP_W-1:0] dd;
        logic signed [STEP_W-1:0] delta;
        logic signed [STEP_W-1:0] esz;
        ds    = $signed(STEP_W'(s));
        dd    = $signed(STEP_W'(d));
        delta = (dd - ds) <<< sh;
        esz   = $signed(STEP_W'(1) << sh);
        return delta - esz + $signed(STEP_W'(1));
    endfunction

    logic [OFF_W-1:0]  o_top, o_bot, o_es, o_ed, o_fs, o_fd;
    logic [BYTE_W-1:0] b_top, b_bot;

    assign o_top = offset_of(plan.top,   xs, xw, rp, yh);
    assign o_bot = offset_of(plan.bot,   xs, xw, rp, yh);
    assign o_es  = offset_of(plan.e_src, xs, xw, rp, yh);
    assign o_ed  = offset_of(plan.e_dst, xs, xw, rp, yh);
    assign o_fs  = offset_of(plan.f_src, xs, xw, rp, yh);
    assign o_fd  = offset_of(plan.f_dst, xs, xw, rp, yh);

    assign b_top = BYTE_W'(o_top) << esh;
    assign b_bot = BYTE_W'(o_bot) << esh;

    assign top   = base + ADDR_W'(b_top);
    assign bot   = base + ADDR_W'(b_bot) + (bump ? ADDR_W'(2) : ADDR_W'(0));
    assign estep = step_of(o_es, o_ed, esh);
    assign fstep = step_of(o_fs, o_fd, esh);
endmodule

// File: rtl/rfb_param_calc.sv
module rfb_param_calc
    import rfb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DIM_W   = 12,
    parameter int SCALE_W = 4,
    localparam int STEP_W = 2 * DIM_W + SCALE_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic [1:0]               elem_code,
    input  logic [DIM_W-1:0]         width,
    input  logic [DIM_W-1:0]         height,
    input  logic [DIM_W-1:0]         virt_width,
    input  logic [SCALE_W-1:0]       x_scale,
    input  logic [SCALE_W-1:0]       y_scale,
    input  logic [2:0]               rot_code,
    input  logic                     mirror,
    input  logic                     legacy_mode,
    output logic                     busy,
    output logic                     done,
    output logic                     err_geom,
    output logic                     err_mode,
    output logic [ADDR_W-1:0]        top_addr,
    output logic [ADDR_W-1:0]        bottom_addr,
    output logic [DIM_W-1:0]         elem_count,
    output logic [DIM_W-1:0]         frame_count,
    output logic signed [STEP_W-1:0] elem_step,
    output logic signed [STEP_W-1:0] frame_step
);
    localparam int PITCH_W = DIM_W + SCALE_W;
    localparam int OFF_W   = 2 * DIM_W + SCALE_W;

    state_e state, state_nx;

    // latched request
    logic [ADDR_W-1:0]  base_q;
    logic [1:0]         esc_q;
    logic [DIM_W-1:0]   w_q, h_q, vw_q;
    logic [SCALE_W-1:0] xs_q, ys_q;
    logic [2:0]         rot_q;
    logic               mir_q, leg_q;

    // products
    logic [PITCH_W-1:0] rp_q, xw_q;
    logic [OFF_W-1:0]   yh_q;

    logic [DIM_W-1:0]   mul_a;
    logic [PITCH_W-1:0] mul_b;
    logic [OFF_W-1:0]   mul_p;

    logic               geom_bad, mode_bad, bump;
    scan_plan_t         plan;
    logic               swap_dims;
    logic [ADDR_W-1:0]  calc_top, calc_bot;
    logic signed [STEP_W-1:0] calc_es, calc_fs;

    assign busy     = (state != ST_IDLE);
    assign geom_bad = (vw_q < w_q) || (w_q == '0) || (h_q == '0);
    assign mode_bad = rot_q[2] || (esc_q == 2'd3);
    assign bump     = leg_q && (esc_q == 2'd2) && (rot_q[1:0] == 2'd0) && !mir_q;

    // one multiplier, operands chosen by state
    always_comb begin
        unique case (state)
            ST_PITCH: begin mul_a = vw_q;               mul_b = PITCH_W'(ys_q); end
            ST_XSPAN: begin mul_a = w_q - DIM_W'(1);    mul_b = PITCH_W'(xs_q); end
            ST_YSPAN: begin mul_a = h_q - DIM_W'(1);    mul_b = rp_q;           end
            default:  begin mul_a = '0;                 mul_b = '0;             end
        endcase
    end

    rfb_mul #(.A_W(DIM_W), .B_W(PITCH_W)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .p (mul_p)
    );

    rfb_scan_order u_order (
        .quad      (rot_q[1:0]),
        .mirror    (mir_q),
        .plan      (plan),
        .swap_dims (swap_dims)
    );

    rfb_corner_math #(
        .ADDR_W (ADDR_W), .PITCH_W(PITCH_W), .OFF_W(OFF_W), .STEP_W(STEP_W)
    ) u_math (
        .base  (base_q),
        .xs    (PITCH_W'(xs_q)),
        .xw    (xw_q),
        .rp    (rp_q),
        .yh    (yh_q),
        .esh   (esc_q),
        .bump  (bump),
        .plan  (plan),
        .top   (calc_top),
        .bot   (calc_bot),
        .estep (calc_es),
        .fstep (calc_fs)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_CHECK;
            ST_CHECK: state_nx = (geom_bad || mode_bad) ? ST_IDLE : ST_PITCH;
            ST_PITCH: state_nx = ST_XSPAN;
            ST_XSPAN: state_nx = ST_YSPAN;
            ST_YSPAN: state_nx = ST_FINAL;
            ST_FINAL: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0; esc_q <= '0; w_q <= '0; h_q <= '0; vw_q <= '0;
            xs_q <= '0; ys_q <= '0; rot_q <= '0; mir_q <= 1'b0; leg_q <= 1'b0;
            rp_q <= '0; xw_q <= '0; yh_q <= '0;
            done <= 1'b0; err_geom <= 1'b0; err_mode <= 1'b0;
            top_addr <= '0; bottom_addr <= '0;
            elem_count <= '0; frame_count <= '0;
            elem_step <= '0; frame_step <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    base_q   <= base_addr;
                    esc_q    <= elem_code;
                    w_q      <= width;
                    h_q      <= height;
                    vw_q     <= (virt_width == '0) ? width : virt_width;
                    xs_q     <= (x_scale == '0) ? SCALE_W'(1) : x_scale;
                    ys_q     <= (y_scale == '0) ? SCALE_W'(1) : y_scale;
                    rot_q    <= rot_code;
                    mir_q    <= mirror;
                    leg_q    <= legacy_mode;
                    err_geom <= 1'b0;
                    err_mode <= 1'b0;
                end
                ST_CHECK: begin
                    err_geom <= geom_bad;
                    err_mode <= mode_bad;
                    done     <= geom_bad || mode_bad;
                end
                ST_PITCH: rp_q <= mul_p[PITCH_W-1:0];
                ST_XSPAN: xw_q <= mul_p[PITCH_W-1:0];
                ST_YSPAN: yh_q <= mul_p;
                ST_FINAL: begin
                    top_addr    <= calc_top;
                    bottom_addr <= calc_bot;
                    elem_count  <= swap_dims ? h_q : w_q;
                    frame_count <= swap_dims ? w_q : h_q;
                    elem_step   <= calc_es;
                    frame_step  <= calc_fs;
                    done        <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(top_addr) && $stable(bottom_addr) &&
                               $stable(elem_step) && $stable(frame_step) &&
                               $stable(err_geom) && $stable(err_mode))); // R9
    AST_GEOM_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_geom) |-> ($stable(top_addr) && $stable(bottom_addr) &&
                                $stable(frame_step))); // R5
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err_mode) |-> ($stable(top_addr) && $stable(bottom_addr) &&
                                $stable(elem_step))); // R6
    AST_COUNT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err_geom && !err_mode) |->
            ((elem_count == w_q && frame_count == h_q) ||
             (elem_count == h_q && frame_count == w_q))); // R4
endmodule

// File: tb/rfb_param_calc_tb.sv
module rfb_param_calc_tb_top;
    localparam int ADDR_W  = 32;
    localparam int DIM_W   = 10;
    localparam int SCALE_W = 3;
    localparam int STEP_W  = 2 * DIM_W + SCALE_W + 4;

    typedef struct packed {
        logic [2:0]         rot;
        logic               mir;
        logic [1:0]         esc;
        logic [DIM_W-1:0]   w;
        logic [DIM_W-1:0]   h;
        logic [DIM_W-1:0]   vw;
        logic [SCALE_W-1:0] xs;
        logic [SCALE_W-1:0] ys;
        logic               leg;
        logic [ADDR_W-1:0]  base;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 2'd1, 10'd8,    10'd4,    10'd0,    3'd0, 3'd0, 1'b0, 32'h0000_1000},
        '{3'd0, 1'b1, 2'd1, 10'd8,    10'd4,    10'd16,   3'd1, 3'd1, 1'b0, 32'h0000_2000},
        '{3'd1, 1'b0, 2'd2, 10'd5,    10'd3,    10'd8,    3'd2, 3'd1, 1'b0, 32'h8000_0000},
        '{3'd1, 1'b1, 2'd0, 10'd7,    10'd9,    10'd7,    3'd1, 3'd3, 1'b0, 32'h0000_0040},
        '{3'd2, 1'b0, 2'd1, 10'd6,    10'd6,    10'd10,   3'd1, 3'd2, 1'b0, 32'h0010_0000},
        '{3'd2, 1'b1, 2'd2, 10'd3,    10'd2,    10'd4,    3'd3, 3'd0, 1'b0, 32'h0000_0500},
        '{3'd3, 1'b0, 2'd0, 10'd9,    10'd5,    10'd12,   3'd0, 3'd2, 1'b0, 32'h0000_7700},
        '{3'd3, 1'b1, 2'd1, 10'd4,    10'd8,    10'd4,    3'd2, 3'd2, 1'b0, 32'h0000_9000},
        '{3'd0, 1'b0, 2'd2, 10'd10,   10'd2,    10'd0,    3'd1, 3'd1, 1'b1, 32'h0000_3000},
        '{3'd2, 1'b0, 2'd2, 10'd10,   10'd2,    10'd0,    3'd1, 3'd1, 1'b1, 32'h0000_3000},
        '{3'd0, 1'b0, 2'd2, 10'd1023, 10'd1023, 10'd1023, 3'd7, 3'd7, 1'b0, 32'hFFFF_F000},
        '{3'd3, 1'b1, 2'd2, 10'd1023, 10'd1023, 10'd1023, 3'd7, 3'd7, 1'b0, 32'h0000_0000},
        '{3'd1, 1'b0, 2'd0, 10'd1,    10'd1,    10'd0,    3'd0, 3'd0, 1'b0, 32'h0000_0000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [ADDR_W-1:0]  base_addr = '0;
    logic [1:0]         elem_code = '0;
    logic [DIM_W-1:0]   width = '0, height = '0, virt_width = '0;
    logic [SCALE_W-1:0] x_scale = '0, y_scale = '0;
    logic [2:0]         rot_code = '0;
    logic               mirror = 1'b0, legacy_mode = 1'b0;
    logic               busy, done, err_geom, err_mode;
    logic [ADDR_W-1:0]  top_addr, bottom_addr;
    logic [DIM_W-1:0]   elem_count, frame_count;
    logic signed [STEP_W-1:0] elem_step, frame_step;

    always #5 clk = ~clk;

    rfb_param_calc #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .SCALE_W(SCALE_W)) dut_i (
        .clk, .rst_n, .start, .base_addr, .elem_code, .width, .height,
        .virt_width, .x_scale, .y_scale, .rot_code, .mirror, .legacy_mode,
        .busy, .done, .err_geom, .err_mode, .top_addr, .bottom_addr,
        .elem_count, .frame_count, .elem_step, .frame_step
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // model state
    longint m_base, m_vw, m_xs, m_ys, m_es;
    longint exp_top, exp_bot, exp_es, exp_fs, exp_ec, exp_fc;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint pix(input longint x, input longint y);
        return m_base + (y * m_vw * m_ys + x * m_xs) * m_es;
    endfunction

    function automatic longint stp(input longint sx, input longint sy,
                                   input longint dx, input longint dy);
        return pix(dx, dy) - pix(sx, sy) - m_es + 1;
    endfunction

    task automatic model(input vec_t v);
        longint mw;
        longint mh;
        m_base = longint'(v.base);
        m_vw   = (v.vw == 0) ? longint'(v.w) : longint'(v.vw);
        m_xs   = (v.xs == 0) ? 1 : longint'(v.xs);
        m_ys   = (v.ys == 0) ? 1 : longint'(v.ys);
        m_es   = longint'(1) << v.esc;
        mw = longint'(v.w) - 1;
        mh = longint'(v.h) - 1;
        case ({v.rot[1:0], v.mir})
            3'b000: begin exp_top = pix(0,0);   exp_bot = pix(mw,mh); exp_es = stp(0,0,1,0); exp_fs = stp(mw,0,0,1);  end
            3'b001: begin exp_top = pix(mw,0);  exp_bot = pix(0,mh);  exp_es = stp(1,0,0,0); exp_fs = stp(0,0,mw,1);  end
            3'b010: begin exp_top = pix(0,mh);  exp_bot = pix(mw,0);  exp_es = stp(0,1,0,0); exp_fs = stp(0,0,1,mh);  end
            3'b011: begin exp_top = pix(mw,mh); exp_bot = pix(0,0);   exp_es = stp(0,1,0,0); exp_fs = stp(1,0,0,mh);  end
            3'b100: begin exp_top = pix(mw,mh); exp_bot = pix(0,0);   exp_es = stp(1,0,0,0); exp_fs = stp(0,1,mw,0);  end
            3'b101: begin exp_top = pix(0,mh);  exp_bot = pix(mw,0);  exp_es = stp(0,0,1,0); exp_fs = stp(mw,1,0,0);  end
            3'b110: begin exp_top = pix(mw,0);  exp_bot = pix(0,mh);  exp_es = stp(0,0,0,1); exp_fs = stp(1,mh,0,0);  end
            default: begin exp_top = pix(0,0);  exp_bot = pix(mw,mh); exp_es = stp(0,0,0,1); exp_fs = stp(0,mh,1,0);  end
        endcase
        if (v.leg && v.esc == 2'd2 && v.rot[1:0] == 2'd0 && !v.mir) exp_bot = exp_bot + 2;
        exp_top = exp_top & 64'hFFFF_FFFF;
        exp_bot = exp_bot & 64'hFFFF_FFFF;
        exp_ec  = v.rot[0] ? longint'(v.h) : longint'(v.w);
        exp_fc  = v.rot[0] ? longint'(v.w) : longint'(v.h);
    endtask

    task automatic apply(input vec_t v);
        base_addr = v.base; elem_code = v.esc; width = v.w; height = v.h;
        virt_width = v.vw; x_scale = v.xs; y_scale = v.ys; rot_code = v.rot;
        mirror = v.mir; legacy_mode = v.leg;
    endtask

    // pulse start for one edge, return edges until done is seen
    task automatic run(output int lat);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        lat = 0;
        for (int k = 1; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) begin lat = k; break; end
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lat;
        longint snap_top, snap_bot, snap_fs, snap_es;
        vec_t v;

        repeat (3) @(negedge clk);
        // R8: reset values
        chk("R8", "reset busy", longint'(busy), 0);
        chk("R8", "reset done", longint'(done), 0);
        chk("R8", "reset errors", longint'({err_geom, err_mode}), 0);
        chk("R8", "reset top", longint'(top_addr), 0);
        chk("R8", "reset frame_step", longint'($signed(frame_step)), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R7 R8
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            model(VECS[i]);
            run(lat);
            chk("R8", $sformatf("vec%0d latency", i), lat, 5);
            chk((i == 0) ? "R1" : "R2", $sformatf("vec%0d top", i), longint'(top_addr), exp_top);
            chk((i == 8 || i == 9) ? "R7" : "R2", $sformatf("vec%0d bottom", i), longint'(bottom_addr), exp_bot);
            chk("R3", $sformatf("vec%0d elem_step", i), longint'($signed(elem_step)), exp_es);
            chk("R3", $sformatf("vec%0d frame_step", i), longint'($signed(frame_step)), exp_fs);
            chk("R4", $sformatf("vec%0d elem_count", i), longint'(elem_count), exp_ec);
            chk("R4", $sformatf("vec%0d frame_count", i), longint'(frame_count), exp_fc);
            chk("R5", $sformatf("vec%0d no error", i), longint'({err_geom, err_mode}), 0);
        end

        // R8: done lasts one cycle
        @(negedge clk);
        chk("R8", "done single cycle", longint'(done), 0);

        // R6: illegal rotation code keeps results
        v = VECS[2]; apply(v); model(v); run(lat);
        snap_top = longint'(top_addr); snap_bot = longint'(bottom_addr);
        snap_fs = longint'($signed(frame_step)); snap_es = longint'($signed(elem_step));
        v.rot = 3'd5; apply(v); run(lat);
        chk("R6", "bad rotation err_mode", longint'(err_mode), 1);
        chk("R8", "error latency", lat, 1);
        chk("R6", "bad rotation top kept", longint'(top_addr), snap_top);
        chk("R6", "bad rotation frame_step kept", longint'($signed(frame_step)), snap_fs);
        v = VECS[2]; v.esc = 2'd3; apply(v); run(lat);
        chk("R6", "bad size err_mode", longint'(err_mode), 1);
        chk("R6", "bad size elem_step kept", longint'($signed(elem_step)), snap_es);

        // R5: geometry errors
        v = VECS[2]; v.vw = 10'd3; apply(v); run(lat);
        chk("R5", "narrow pitch err_geom", longint'(err_geom), 1);
        chk("R5", "narrow pitch err_mode clear", longint'(err_mode), 0);
        chk("R5", "narrow pitch bottom kept", longint'(bottom_addr), snap_bot);
        v = VECS[2]; v.h = 10'd0; apply(v); run(lat);
        chk("R5", "zero height err_geom", longint'(err_geom), 1);
        chk("R5", "zero height top kept", longint'(top_addr), snap_top);

        // R9: errors clear on next accepted start
        v = VECS[4]; apply(v); model(v); run(lat);
        chk("R9", "errors cleared", longint'({err_geom, err_mode}), 0);
        chk("R2", "after error top", longint'(top_addr), exp_top);

        // R8: start during busy is ignored
        v = VECS[1]; apply(v); model(v);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        @(posedge clk);
        @(negedge clk) begin start = 1'b1; apply(VECS[6]); end
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        lat = 2;
        for (int k = 3; k <= 20; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) begin lat = k; break; end
        end
        chk("R8", "busy start latency", lat, 5);
        chk("R8", "busy start top", longint'(top_addr), exp_top);
        chk("R8", "busy start frame_step", longint'($signed(frame_step)), exp_fs);
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done || busy) lat++;
        end
        chk("R8", "no second run", lat, 0);

        // R9: hold with changing inputs and no start
        snap_top = longint'(top_addr); snap_fs = longint'($signed(frame_step));
        apply(VECS[10]);
        repeat (10) @(negedge clk);
        chk("R9", "hold top", longint'(top_addr), snap_top);
        chk("R9", "hold frame_step", longint'($signed(frame_step)), snap_fs);
        chk("R9", "hold elem_count", longint'(elem_count), exp_ec);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule